// File: doc/BRIEF.md
# Eight-Channel Pairable PWM Generator

This block produces eight pulse-width-modulated outputs from eight 8-bit channels. Each channel has its own period, duty, enable, output polarity and alignment (edge or centre). Each channel also selects one of four clock-enable pulse inputs as its counting tick. Neighbouring channels form pairs, and each pair can be joined into one 16-bit channel. The result is four wide channels, or any mix of wide and narrow channels.

Software writes period and duty values through a byte-wide write port into holding registers. A running channel copies them into its working registers only when its counter returns to zero at the end of a period. A disabled channel copies them on every clock, so a new setting is in place before the channel starts.

A shutdown input forces every enabled output to a per-pin idle level at once. The shutdown is latched. It stays in force after the input drops, until a clear pulse arrives while the input is low.

Top module: `pwm_unit`

## Requirements
- R1: While reset is active and after its release with no channel enabled, every bit of `pwm_out` is 0.
- R2: In edge-aligned mode (`ch_center` bit = 0) with period P ≥ 1 and duty D, the pin is active for the first D ticks of each P-tick period. The first tick starts in the cycle the channel is enabled.
- R3: In centre-aligned mode (`ch_center` bit = 1) the counter climbs from 0 to P−1, holds there for one tick, then falls back to 0. The period is 2·P ticks, and the pin is active while the counter value is below D.
- R4: A duty of 0 holds the pin at its inactive level. A duty at or above the period holds it at its active level.
- R5: A `ch_pol` bit of 1 makes the active level high, and 0 makes it low. A disabled channel drives its pin low whatever its polarity.
- R6: On an enabled channel, a new period or duty value takes effect only at the start of the next period. Until then the current period completes with the old values.
- R7: While a channel is disabled, written values move to its working registers within two clocks. Enabling then starts a fresh period at count 0 with those values.
- R8: The 2-bit clock select of channel c is `ch_src[2c+1:2c]`. Code 0 selects `src_tick[0]`, 1 selects `src_tick[1]`, 2 selects `src_tick[2]` and 3 selects `src_tick[3]`. The counter advances only on clocks where the selected tick is high.
- R9: With `pair_cat[p]` = 1, channels 2p and 2p+1 form one 16-bit channel. Its period and duty take the high byte from channel 2p+1 and the low byte from channel 2p. The enable, polarity, alignment and clock select come from channel 2p+1. The result appears on pin 2p+1, and pin 2p is held low.
- R10: While `sd_in` is high, or a shutdown is latched, every enabled pin shows its `sd_idle` bit. Disabled pins stay low. The counters keep running during shutdown.
- R11: A latched shutdown clears only on a clock where `sd_clr` is high and `sd_in` is low. Normal output resumes in the next cycle.
- R12: A write with `wr_en` high stores `wr_data` into the holding register of channel `wr_addr[2:0]`. `wr_addr[3]` = 0 selects the period and 1 selects the duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 4 | Clock-enable pulses for the four tick sources |
| ch_en | input | 8 | Per-channel enable |
| ch_pol | input | 8 | Per-channel active level (1 = high) |
| ch_center | input | 8 | Per-channel alignment (1 = centre) |
| ch_src | input | 16 | Per-channel 2-bit tick source select |
| pair_cat | input | 4 | Per-pair join into one 16-bit channel |
| wr_en | input | 1 | Holding-register write strobe |
| wr_addr | input | 4 | Bit 3: period/duty, bits 2:0: channel |
| wr_data | input | 8 | Byte written |
| sd_in | input | 1 | Shutdown request |
| sd_clr | input | 1 | Clears a latched shutdown |
| sd_idle | input | 8 | Per-pin level forced during shutdown |
| pwm_out | output | 8 | PWM pins |

## Verification
The hardest case to reach from the ports is a holding-register write that lands inside a running period. It must be applied early enough to be stored before the wrap, and the old values must still govern the rest of the current period. The stimulus counts ticks from the enable cycle and issues the duty write at tick 1 and the period write one tick into the second period. It then checks every cycle across both boundaries. A second hard case is shutdown release. The clear is pulsed once while the request is still high, which must do nothing, and again after the request drops. The output is compared cycle by cycle against the running counter throughout.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned SRC_W   = $clog2(NUM_SRC);

  typedef enum logic [SRC_W-1:0] {
    SRC_A  = 2'd0,
    SRC_B  = 2'd1,
    SRC_SA = 2'd2,
    SRC_SB = 2'd3
  } pwm_src_e;
endpackage

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         center,
  input  logic         pol,
  input  logic         tick,
  input  logic [W-1:0] sh_per,
  input  logic [W-1:0] sh_dty,
  output logic         pin
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] per_q, per_d;
  logic [W-1:0] dty_q, dty_d;
  logic         down_q, down_d;
  logic [W:0]   cnt_inc;
  logic         top_hit;
  logic         active;

  assign cnt_inc = {1'b0, cnt_q} + (W+1)'(1);
  assign top_hit = cnt_inc >= {1'b0, per_q};

  always_comb begin
    cnt_d  = cnt_q;
    per_d  = per_q;
    dty_d  = dty_q;
    down_d = down_q;
    if (!en) begin
      cnt_d  = '0;
      down_d = 1'b0;
      per_d  = sh_per;
      dty_d  = sh_dty;
    end else if (tick) begin
      if (!center) begin
        down_d = 1'b0;
        if (top_hit) begin
          cnt_d = '0;
          per_d = sh_per;
          dty_d = sh_dty;
        end else begin
          cnt_d = cnt_inc[W-1:0];
        end
      end else if (!down_q) begin
        if (top_hit) down_d = 1'b1;
        else         cnt_d  = cnt_inc[W-1:0];
      end else begin
        if (cnt_q == '0) begin
          down_d = 1'b0;
          per_d  = sh_per;
          dty_d  = sh_dty;
        end else begin
          cnt_d = cnt_q - W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      dty_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      dty_q  <= dty_d;
      down_q <= down_d;
    end
  end

  assign active = cnt_q < dty_q;
  assign pin    = en & (pol ? active : ~active);

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q < per_q || cnt_q == '0));

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && cnt_q != '0) |-> ($stable(per_q) && $stable(dty_q)));
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cat,
  input  logic [1:0]    en,
  input  logic [1:0]    pol,
  input  logic [1:0]    center,
  input  logic [1:0]    tick,
  input  logic [2*CW-1:0] per,
  input  logic [2*CW-1:0] dty,
  output logic [1:0]    pin
);
  localparam int unsigned WW = 2 * CW;

  logic lo_pin, hi_pin, wide_pin;

  pwm_core #(.W(CW)) u_lo (
    .clk(clk), .rst_n(rst_n), .en(en[0] & ~cat), .center(center[0]),
    .pol(pol[0]), .tick(tick[0]), .sh_per(per[CW-1:0]),
    .sh_dty(dty[CW-1:0]), .pin(lo_pin)
  );

  pwm_core #(.W(CW)) u_hi (
    .clk(clk), .rst_n(rst_n), .en(en[1] & ~cat), .center(center[1]),
    .pol(pol[1]), .tick(tick[1]), .sh_per(per[WW-1:CW]),
    .sh_dty(dty[WW-1:CW]), .pin(hi_pin)
  );

  pwm_core #(.W(WW)) u_wide (
    .clk(clk), .rst_n(rst_n), .en(en[1] & cat), .center(center[1]),
    .pol(pol[1]), .tick(tick[1]), .sh_per(per), .sh_dty(dty),
    .pin(wide_pin)
  );

  always_comb begin
    if (cat) pin = {wide_pin, 1'b0};
    else     pin = {hi_pin, lo_pin};
  end

  // R9
  cat_idle_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cat && !en[1]) |-> (pin == 2'b00));
endmodule

// File: rtl/pwm_shutdown.sv
module pwm_shutdown (
  input  logic clk,
  input  logic rst_n,
  input  logic sd_in,
  input  logic sd_clr,
  output logic force_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (sd_in)       flag_d = 1'b1;
    else if (sd_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign force_o = sd_in | flag_q;

  // R10
  flag_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_in |=> flag_q);

  // R11
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_in && sd_clr) |=> !flag_q);

  // R11
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !sd_clr) |=> flag_q);
endmodule

// File: rtl/pwm_unit.sv
module pwm_unit
  import pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CW     = 8,
  localparam int unsigned NPAIR = NUM_CH / 2,
  localparam int unsigned AW    = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SRC-1:0]      src_tick,
  input  logic [NUM_CH-1:0]       ch_en,
  input  logic [NUM_CH-1:0]       ch_pol,
  input  logic [NUM_CH-1:0]       ch_center,
  input  logic [SRC_W*NUM_CH-1:0] ch_src,
  input  logic [NPAIR-1:0]        pair_cat,
  input  logic                    wr_en,
  input  logic [AW:0]             wr_addr,
  input  logic [CW-1:0]           wr_data,
  input  logic                    sd_in,
  input  logic                    sd_clr,
  input  logic [NUM_CH-1:0]       sd_idle,
  output logic [NUM_CH-1:0]       pwm_out
);
  logic [1:0]             rsync_q;
  logic                   rst_ns;
  logic [NUM_CH*CW-1:0]   per_flat, dty_flat;
  logic [NUM_CH-1:0]      tick_v;
  logic [NUM_CH-1:0]      raw;
  logic [NUM_CH-1:0]      en_eff;
  logic                   sd_force;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [CW-1:0] per_q, per_d, dty_q, dty_d;
    logic          hit_per, hit_dty;
    pwm_src_e      sel;
    logic          tk;

    assign hit_per = wr_en && (wr_addr == {1'b0, AW'(c)});
    assign hit_dty = wr_en && (wr_addr == {1'b1, AW'(c)});

    always_comb begin
      per_d = per_q;
      dty_d = dty_q;
      if (hit_per) per_d = wr_data;
      if (hit_dty) dty_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns) begin
        per_q <= '0;
        dty_q <= '0;
      end else begin
        per_q <= per_d;
        dty_q <= dty_d;
      end
    end

    assign per_flat[c*CW +: CW] = per_q;
    assign dty_flat[c*CW +: CW] = dty_q;

    always_comb begin
      sel = pwm_src_e'(ch_src[c*SRC_W +: SRC_W]);
      case (sel)
        SRC_A:   tk = src_tick[0];
        SRC_B:   tk = src_tick[1];
        SRC_SA:  tk = src_tick[2];
        default: tk = src_tick[3];
      endcase
    end
    assign tick_v[c] = tk;
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pwm_pair #(.CW(CW)) u_pair (
      .clk    (clk),
      .rst_n  (rst_ns),
      .cat    (pair_cat[p]),
      .en     (ch_en[2*p +: 2]),
      .pol    (ch_pol[2*p +: 2]),
      .center (ch_center[2*p +: 2]),
      .tick   (tick_v[2*p +: 2]),
      .per    (per_flat[2*p*CW +: 2*CW]),
      .dty    (dty_flat[2*p*CW +: 2*CW]),
      .pin    (raw[2*p +: 2])
    );
    assign en_eff[2*p]   = ch_en[2*p] & ~pair_cat[p];
    assign en_eff[2*p+1] = ch_en[2*p+1];
  end

  pwm_shutdown u_sd (
    .clk     (clk),
    .rst_n   (rst_ns),
    .sd_in   (sd_in),
    .sd_clr  (sd_clr),
    .force_o (sd_force)
  );

  always_comb begin
    if (sd_force) pwm_out = sd_idle & en_eff;
    else          pwm_out = raw;
  end

  // R10
  shutdown_force_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    sd_in |-> ((pwm_out & en_eff) == (sd_idle & en_eff)));

  // R5
  disabled_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ((pwm_out & ~en_eff) == '0));
endmodule

// File: tb/pwm_unit_bench.sv
module pwm_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic        clk;
  logic        rst_n;
  logic [3:0]  src_tick;
  logic [7:0]  ch_en, ch_pol, ch_center;
  logic [15:0] ch_src;
  logic [3:0]  pair_cat;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        sd_in, sd_clr;
  logic [7:0]  sd_idle;
  logic [7:0]  pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] mask_q[$];
  logic [7:0] val_q[$];
  string      req_q[$];

  pwm_unit u_pwm_unit (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .ch_en(ch_en),
    .ch_pol(ch_pol), .ch_center(ch_center), .ch_src(ch_src),
    .pair_cat(pair_cat), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sd_in(sd_in), .sd_clr(sd_clr),
    .sd_idle(sd_idle), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: compares at the falling edge against the queued expectation
  always @(negedge clk) begin
    logic [7:0] m, v;
    string r;
    if (mask_q.size() != 0) begin
      m = mask_q.pop_front();
      v = val_q.pop_front();
      r = req_q.pop_front();
      checks++;
      if ((pwm_out & m) !== (v & m)) begin
        fails++;
        $display("FAIL %s: pwm_out=%b expected=%b mask=%b at %0t",
                 r, pwm_out & m, v & m, m, $time);
      end
    end
  end

  // Expected pin level from the requirement formulas (R2, R3, R4, R5)
  function automatic bit lvl(int per, int dty, bit ctr, bit pol, int k);
    int pe, ph, v;
    bit act;
    pe = (per == 0) ? 1 : per;
    ph = k % (ctr ? 2*pe : pe);
    v  = (ctr && ph >= pe) ? (2*pe - 1 - ph) : ph;
    act = (v < dty);
    return pol ? act : !act;
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [7:0] m, input logic [7:0] v, input string r);
    mask_q.push_back(m);
    val_q.push_back(v);
    req_q.push_back(r);
  endtask

  // R12 write encoding: addr[3] 0=period 1=duty, addr[2:0]=channel
  task automatic wr(input int c, input bit isdty, input logic [7:0] d);
    cyc();
    wr_en   = 1'b1;
    wr_addr = {isdty, 3'(c)};
    wr_data = d;
    cyc();
    wr_en   = 1'b0;
  endtask

  task automatic run_chan(input int c, input int per, input int dty, input bit ctr,
                          input bit pol, input int n, input string req);
    logic [7:0] m;
    m = 8'(1) << c;
    wr(c, 1'b0, 8'(per));
    wr(c, 1'b1, 8'(dty));
    ch_pol[c] = pol;
    ch_center[c] = ctr;
    ch_src[2*c +: 2] = 2'd0;
    cyc();
    cyc();
    cyc();
    ch_en[c] = 1'b1;
    for (int k = 0; k < n; k++) begin
      if (k > 0) cyc();
      push(m, {7'd0, lvl(per, dty, ctr, pol, k)} << c, req);
    end
    cyc();
    ch_en[c] = 1'b0;
    push(m, 8'h00, "R5");
  endtask

  initial begin
    rst_n = 1'b0; src_tick = 4'b1111; ch_en = '0; ch_pol = '0; ch_center = '0;
    ch_src = '0; pair_cat = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    sd_in = 1'b0; sd_clr = 1'b0; sd_idle = '0;

    // R1: reset state
    for (int i = 0; i < 4; i++) begin cyc(); push(8'hFF, 8'h00, "R1"); end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin cyc(); push(8'hFF, 8'h00, "R1"); end

    // R2: edge aligned
    run_chan(0, 5, 2, 1'b0, 1'b1, 15, "R2");
    // R3: centre aligned
    run_chan(1, 4, 1, 1'b1, 1'b1, 20, "R3");
    run_chan(7, 3, 2, 1'b1, 1'b1, 14, "R3");
    // R5: active-low polarity
    run_chan(2, 6, 2, 1'b0, 1'b0, 14, "R5");
    // R4: duty extremes
    run_chan(3, 6, 0, 1'b0, 1'b1, 8, "R4");
    run_chan(3, 6, 9, 1'b0, 1'b1, 8, "R4");
    run_chan(5, 3, 3, 1'b1, 1'b1, 8, "R4");

    // R8: ch4 on source code 1, ch6 on source code 3 held idle
    wr(4, 1'b0, 8'd4); wr(4, 1'b1, 8'd2);
    wr(6, 1'b0, 8'd4); wr(6, 1'b1, 8'd2);
    ch_src[9:8] = 2'd1; ch_src[13:12] = 2'd3;
    ch_pol[4] = 1'b1; ch_pol[6] = 1'b1; ch_center[4] = 1'b0; ch_center[6] = 1'b0;
    src_tick[1] = 1'b0; src_tick[3] = 1'b0;
    cyc(); cyc();
    begin
      int k;
      k = 0;
      for (int i = 0; i < 24; i++) begin
        cyc();
        if (i == 0) begin ch_en[4] = 1'b1; ch_en[6] = 1'b1; end
        src_tick[1] = i[0];
        push(8'h50, ({7'd0, lvl(4, 2, 1'b0, 1'b1, k)} << 4) | 8'h40, "R8");
        if (i[0]) k++;
      end
    end
    cyc();
    ch_en[4] = 1'b0; ch_en[6] = 1'b0; src_tick = 4'b1111;

    // R6: mid-period writes wait for the period end
    wr(0, 1'b0, 8'd5); wr(0, 1'b1, 8'd2);
    ch_pol[0] = 1'b1; ch_center[0] = 1'b0;
    cyc(); cyc();
    for (int k = 0; k < 26; k++) begin
      bit e;
      cyc();
      if (k == 0) ch_en[0] = 1'b1;
      wr_en = 1'b0;
      if (k == 1) begin wr_en = 1'b1; wr_addr = 4'b1000; wr_data = 8'd4; end
      if (k == 6) begin wr_en = 1'b1; wr_addr = 4'b0000; wr_data = 8'd8; end
      if (k < 5)       e = lvl(5, 2, 1'b0, 1'b1, k);
      else if (k < 10) e = lvl(5, 4, 1'b0, 1'b1, k - 5);
      else             e = lvl(8, 4, 1'b0, 1'b1, k - 10);
      push(8'h01, {7'd0, e}, "R6");
    end
    cyc();
    wr_en = 1'b0;
    ch_en[0] = 1'b0;
    push(8'h01, 8'h00, "R5");

    // R7: values written while disabled apply at once on enable
    run_chan(0, 3, 1, 1'b0, 1'b1, 9, "R7");

    // R9: join pair 1 into one 16-bit channel, period 0x0100, duty 0x0080
    pair_cat[1] = 1'b1;
    wr(2, 1'b0, 8'h00); wr(3, 1'b0, 8'h01);
    wr(2, 1'b1, 8'h80); wr(3, 1'b1, 8'h00);
    ch_pol[2] = 1'b0; ch_center[2] = 1'b1;
    ch_pol[3] = 1'b1; ch_center[3] = 1'b0;
    ch_src[5:4] = 2'd0; ch_src[7:6] = 2'd0;
    cyc(); cyc();
    for (int k = 0; k < 270; k++) begin
      cyc();
      if (k == 0) begin ch_en[2] = 1'b1; ch_en[3] = 1'b1; end
      push(8'h0C, {4'd0, lvl(256, 128, 1'b0, 1'b1, k), 3'd0}, "R9");
    end
    cyc();
    ch_en[2] = 1'b0; ch_en[3] = 1'b0;
    push(8'h0C, 8'h00, "R9");
    cyc();
    pair_cat[1] = 1'b0;

    // R10 / R11: shutdown force, latch and clear
    wr(0, 1'b0, 8'd4); wr(0, 1'b1, 8'd1);
    ch_pol[0] = 1'b1; ch_center[0] = 1'b0;
    sd_idle = 8'h03;
    cyc(); cyc();
    for (int i = 0; i < 20; i++) begin
      cyc();
      if (i == 0) ch_en[0] = 1'b1;
      sd_in  = (i >= 4 && i < 7);
      sd_clr = (i == 5 || i == 10);
      if (i >= 4 && i <= 10)
        push(8'h03, 8'h01, (i < 7) ? "R10" : "R11");
      else
        push(8'h03, {7'd0, lvl(4, 1, 1'b0, 1'b1, i)}, (i > 10) ? "R11" : "R10");
    end
    cyc();
    sd_in = 1'b0; sd_clr = 1'b0; ch_en[0] = 1'b0;
    push(8'hFF, 8'h00, "R5");
    cyc(); cyc();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule